// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 30-bit virtual address into a 32-bit physical address by reading two entries from a page table kept in memory. The address splits into three fields. From the top down they are an 8-bit outer index, a 10-bit inner index and a 12-bit page offset. A root register holds the frame number of the outer table, called the directory. The walker first fetches the directory entry that the outer index selects. If that entry is present, the walker then fetches the leaf entry that the inner index selects, inside the inner table named by the directory entry. Each entry is 4 bytes, so a table of 1024 entries fills one 4 KB page exactly.

A translation starts with a request handshake and ends with a one-cycle response. The response carries either the physical address or a fault, and a fault says which level was not present. Memory reads go out through a request/valid port whose latency can vary. The walker performs its two reads strictly one after the other.

Top module: `pgwalk_top`

## Requirements
- R1: The first read of a walk goes to address (root_frame << 12) + outer_index * 4, where outer_index is vaddr[29:22]. In every table entry, bit 0 is the present bit and bits 31:12 are the frame number.
- R2: When the directory entry is present, the second read goes to (dir_frame << 12) + inner_index * 4, where inner_index is vaddr[21:12] and dir_frame is bits 31:12 of the directory entry.
- R3: When both entries are present, the response has rsp_fault = 0 and rsp_paddr = (leaf_frame << 12) | vaddr[11:0].
- R4: A directory entry with bit 0 clear ends the walk with rsp_fault = 1 and rsp_fault_lvl = 0 (outer), and no second memory read is issued.
- R5: A leaf entry with bit 0 clear ends the walk with rsp_fault = 1 and rsp_fault_lvl = 1 (inner), after exactly two reads.
- R6: Once mem_req is raised, it stays high and mem_addr stays unchanged until the cycle in which mem_rvalid returns the data, for any read latency.
- R7: A root register write made while a walk is in progress does not change that walk. The next accepted walk uses the new root frame.
- R8: rsp_valid is high for exactly one cycle per walk. req_ready is high only while the walker is idle, and a request raised while it is low is not taken.
- R9: After reset, req_ready = 1, mem_req = 0, rsp_valid = 0, and the root frame is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker is idle and will accept a request |
| req_vaddr | input | 30 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle pulse marking a completed walk |
| rsp_fault | output | 1 | Walk ended on an entry that was not present |
| rsp_fault_lvl | output | 1 | Level of the fault: 0 outer, 1 inner |
| rsp_paddr | output | 32 | Translated physical address |
| root_we | input | 1 | Write strobe for the root register |
| root_frame | input | 20 | Frame number of the directory |
| mem_req | output | 1 | Memory read request, held until data returns |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The bench targets a directory miss. A design that issues a leaf read anyway would show a second address in the read log. The same case also catches a fault reported at the wrong level. The bench uses the extreme index values 0x00, 0xFF and 0x3FF, together with offsets 0x000 and 0xFFF. A slip in the field slicing or in the times-four scaling therefore lands on a wrong entry address or a wrong physical address. The bench writes the root register in the middle of a walk and varies the read latency from zero to seven cycles. A walker that reads the live register would then fetch from the wrong directory. A walker that lets the read address drift before data arrives would trip the stability count. The bench also raises a request while the walker is busy. A design that took that request would return a result for the wrong address.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_LEAF = 2'd2,
    ST_RESP = 2'd3
  } walk_st_e;

  localparam int unsigned PRESENT_BIT = 0;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int unsigned OUT_W   = 8,
  parameter int unsigned IN_W    = 10,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned FRAME_W = PA_W - OFF_W
) (
  input  logic [FRAME_W-1:0] root_frame,
  input  logic [OUT_W-1:0]   outer_idx,
  input  logic [IN_W-1:0]    inner_idx,
  input  logic [OFF_W-1:0]   page_off,
  input  logic [FRAME_W-1:0] entry_frame,
  output logic [PA_W-1:0]    dir_addr,
  output logic [PA_W-1:0]    leaf_addr,
  output logic [PA_W-1:0]    phys_addr
);
  localparam logic [OFF_W-1:0] ZERO_OFF = '0;

  // entries are 4 bytes: index scaled by two bit positions
  always_comb begin
    dir_addr  = {root_frame, ZERO_OFF}  + PA_W'({outer_idx, 2'b00});
    leaf_addr = {entry_frame, ZERO_OFF} + PA_W'({inner_idx, 2'b00});
    phys_addr = {entry_frame, page_off};
  end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int unsigned VA_W    = 30,
  parameter int unsigned OUT_W   = 8,
  parameter int unsigned IN_W    = 10,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned FRAME_W = PA_W - OFF_W,
  localparam int unsigned LOW_W  = IN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic               rsp_fault_lvl,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               mem_req,
  output logic [PA_W-1:0]    mem_addr,
  input  logic               mem_rvalid,
  input  logic [PA_W-1:0]    mem_rdata,
  input  logic [FRAME_W-1:0] root_frame
);
  walk_st_e st_q, st_d;

  logic [LOW_W-1:0] low_q;
  logic [PA_W-1:0]  addr_q, addr_d;
  logic [PA_W-1:0]  paddr_q, paddr_d;
  logic             fault_q, fault_d, lvl_q, lvl_d;
  logic             accept, addr_en, res_en, present;
  logic [PA_W-1:0]  dir_addr, leaf_addr, phys_addr;
  logic             unused_rdata;

  assign present      = mem_rdata[PRESENT_BIT];
  assign unused_rdata = ^mem_rdata[PA_W-FRAME_W-1:1];

  pgwalk_addr #(
    .OUT_W(OUT_W), .IN_W(IN_W), .OFF_W(OFF_W), .PA_W(PA_W), .FRAME_W(FRAME_W)
  ) u_addr (
    .root_frame  (root_frame),
    .outer_idx   (req_vaddr[VA_W-1 -: OUT_W]),
    .inner_idx   (low_q[LOW_W-1 -: IN_W]),
    .page_off    (low_q[OFF_W-1:0]),
    .entry_frame (mem_rdata[PA_W-1 -: FRAME_W]),
    .dir_addr    (dir_addr),
    .leaf_addr   (leaf_addr),
    .phys_addr   (phys_addr)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (req_valid)  st_d = ST_DIR;
      ST_DIR:  if (mem_rvalid) st_d = present ? ST_LEAF : ST_RESP;
      ST_LEAF: if (mem_rvalid) st_d = ST_RESP;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    accept  = (st_q == ST_IDLE) && req_valid;
    addr_en = accept || ((st_q == ST_DIR) && mem_rvalid && present);
    addr_d  = accept ? dir_addr : leaf_addr;
    res_en  = mem_rvalid && (((st_q == ST_DIR) && !present) || (st_q == ST_LEAF));
    fault_d = !present;
    lvl_d   = (st_q == ST_LEAF);
    paddr_d = ((st_q == ST_LEAF) && present) ? phys_addr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      low_q   <= '0;
      addr_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept)  low_q  <= req_vaddr[LOW_W-1:0];
      if (addr_en) addr_q <= addr_d;
      if (res_en) begin
        paddr_q <= paddr_d;
        fault_q <= fault_d;
        lvl_q   <= lvl_d;
      end
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req       = (st_q == ST_DIR) || (st_q == ST_LEAF);
  assign mem_addr      = addr_q;
  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_fault     = fault_q;
  assign rsp_fault_lvl = lvl_q;
  assign rsp_paddr     = paddr_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R6
  AST_OUTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DIR) && mem_rvalid && !present)
      |=> (rsp_valid && rsp_fault && !rsp_fault_lvl && !mem_req)); // R4
  AST_INNER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_LEAF) && mem_rvalid && !present)
      |=> (rsp_valid && rsp_fault && rsp_fault_lvl)); // R5
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rsp_valid)); // R8
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int unsigned VA_W    = 30,
  parameter int unsigned OUT_W   = 8,
  parameter int unsigned IN_W    = 10,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PA_W    = 32,
  localparam int unsigned FRAME_W = PA_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic               rsp_fault_lvl,
  output logic [PA_W-1:0]    rsp_paddr,
  input  logic               root_we,
  input  logic [FRAME_W-1:0] root_frame,
  output logic               mem_req,
  output logic [PA_W-1:0]    mem_addr,
  input  logic               mem_rvalid,
  input  logic [PA_W-1:0]    mem_rdata
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [FRAME_W-1:0] root_q;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   root_q <= '0;
    else if (root_we) root_q <= root_frame;
  end

  pgwalk_ctrl #(
    .VA_W(VA_W), .OUT_W(OUT_W), .IN_W(IN_W), .OFF_W(OFF_W), .PA_W(PA_W), .FRAME_W(FRAME_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .rsp_paddr     (rsp_paddr),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .root_frame    (root_q)
  );
endmodule

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [29:0] req_vaddr;
  logic        rsp_valid, rsp_fault, rsp_fault_lvl;
  logic [31:0] rsp_paddr;
  logic        root_we;
  logic [19:0] root_frame;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;

  always #5 clk = ~clk;

  pgwalk_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_fault_lvl(rsp_fault_lvl), .rsp_paddr(rsp_paddr), .root_we(root_we),
    .root_frame(root_frame), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int lat    = 1;
  int nlog   = 0;
  int stab_err = 0;
  bit done_flag = 0;
  logic [31:0] addr_log [0:7];
  logic [31:0] mem [logic [31:0]];

  logic        r_fault, r_lvl;
  logic [31:0] r_pa;
  int          r_reads;

  function automatic logic [29:0] va(input int o, input int i, input int f);
    return 30'((o << 22) | (i << 12) | f);
  endfunction

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // memory model: variable latency, checks request stability (R6)
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rst_n && mem_req) begin
        logic [31:0] a;
        a = mem_addr;
        if (nlog < 8) addr_log[nlog] = a;
        nlog++;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (!mem_req || mem_addr != a) stab_err++;
        end
        mem_rvalid = 1'b1;
        mem_rdata  = rd(a);
      end
    end
  end

  task automatic set_root(input logic [19:0] f);
    root_we = 1'b1;
    root_frame = f;
    @(negedge clk);
    root_we = 1'b0;
  endtask

  task automatic start_walk(input logic [29:0] v);
    while (!req_ready) @(negedge clk);
    nlog = 0;
    req_valid = 1'b1;
    req_vaddr = v;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_walk;
    int n = 0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    r_fault = rsp_fault;
    r_lvl   = rsp_fault_lvl;
    r_pa    = rsp_paddr;
    r_reads = nlog;
    chk(rsp_valid, "R8 response arrives", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    chk(!rsp_valid, "R8 response pulse one cycle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);
    chk(mem_req == 1'b0, "R9 no read after reset", 32'(mem_req), 32'd0);
    chk(rsp_valid == 1'b0, "R9 no response after reset", 32'(rsp_valid), 32'd0);
    // root frame 0 at reset: directory read lands at page 0
    lat = 1;
    start_walk(va(2, 0, 0));
    finish_walk();
    chk(addr_log[0] == 32'h8, "R9 root frame zero", addr_log[0], 32'h8);
  endtask

  task automatic t_basic;
    lat = 2;
    start_walk(va(0, 1, 12'hABC));
    finish_walk();
    chk(addr_log[0] == 32'h0001_0000, "R1 directory address", addr_log[0], 32'h0001_0000);
    chk(addr_log[1] == 32'h0002_0004, "R2 leaf address", addr_log[1], 32'h0002_0004);
    chk(!r_fault && r_pa == 32'hABCD_EABC, "R3 physical address", r_pa, 32'hABCD_EABC);
  endtask

  task automatic t_extremes;
    lat = 0;
    start_walk(va(8'hFF, 0, 12'h123));
    finish_walk();
    chk(addr_log[0] == 32'h0001_03FC, "R1 top outer index", addr_log[0], 32'h0001_03FC);
    chk(addr_log[1] == 32'h0003_0000, "R2 zero inner index", addr_log[1], 32'h0003_0000);
    chk(!r_fault && r_pa == 32'h0000_1123, "R3 zero latency result", r_pa, 32'h0000_1123);
    lat = 5;
    start_walk(va(0, 10'h3FF, 12'hFFF));
    finish_walk();
    chk(addr_log[1] == 32'h0002_0FFC, "R2 top inner index", addr_log[1], 32'h0002_0FFC);
    chk(!r_fault && r_pa == 32'h1234_5FFF, "R3 top offset", r_pa, 32'h1234_5FFF);
  endtask

  task automatic t_outer_miss;
    lat = 3;
    start_walk(va(8'h3F, 1, 0));
    finish_walk();
    chk(r_fault && !r_lvl, "R4 outer fault level", {30'd0, r_fault, r_lvl}, 32'd2);
    chk(r_reads == 1, "R4 single read on outer miss", 32'(r_reads), 32'd1);
    chk(addr_log[0] == 32'h0001_00FC, "R4 miss directory address", addr_log[0], 32'h0001_00FC);
  endtask

  task automatic t_inner_miss;
    lat = 1;
    start_walk(va(0, 5, 12'h010));
    finish_walk();
    chk(r_fault && r_lvl, "R5 inner fault level", {30'd0, r_fault, r_lvl}, 32'd3);
    chk(r_reads == 2, "R5 two reads on inner miss", 32'(r_reads), 32'd2);
  endtask

  task automatic t_latency;
    stab_err = 0;
    lat = 7;
    start_walk(va(0, 1, 12'h001));
    finish_walk();
    chk(!r_fault && r_pa == 32'hABCD_E001, "R6 long latency result", r_pa, 32'hABCD_E001);
    chk(stab_err == 0, "R6 request held stable", 32'(stab_err), 32'd0);
  endtask

  task automatic t_root_midwalk;
    lat = 4;
    start_walk(va(0, 1, 12'hABC));
    set_root(20'h00040);
    finish_walk();
    chk(addr_log[0] == 32'h0001_0000, "R7 walk keeps old root", addr_log[0], 32'h0001_0000);
    chk(!r_fault && r_pa == 32'hABCD_EABC, "R7 walk result unchanged", r_pa, 32'hABCD_EABC);
    start_walk(va(0, 1, 12'h005));
    finish_walk();
    chk(addr_log[0] == 32'h0004_0000, "R7 next walk uses new root", addr_log[0], 32'h0004_0000);
    chk(!r_fault && r_pa == 32'h7777_7005, "R7 new root result", r_pa, 32'h7777_7005);
    set_root(20'h00010);
  endtask

  task automatic t_busy_request;
    lat = 3;
    start_walk(va(0, 1, 12'h0AA));
    chk(!req_ready, "R8 not ready while walking", 32'(req_ready), 32'd0);
    req_valid = 1'b1;
    req_vaddr = va(8'hFF, 0, 12'h777);
    finish_walk();
    req_valid = 1'b0;
    chk(!r_fault && r_pa == 32'hABCD_E0AA, "R8 busy request not taken", r_pa, 32'hABCD_E0AA);
    @(negedge clk);
    chk(req_ready && !mem_req, "R8 idle after walk", {30'd0, req_ready, mem_req}, 32'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    root_we = 1'b0;
    root_frame = '0;
    mem[32'h0000_0008] = 32'h0002_0001;
    mem[32'h0001_0000] = 32'h0002_0001;
    mem[32'h0001_03FC] = 32'h0003_0001;
    mem[32'h0001_00FC] = 32'h0009_0000;
    mem[32'h0002_0000] = 32'h0000_0001;
    mem[32'h0002_0004] = 32'hABCD_E001;
    mem[32'h0002_0FFC] = 32'h1234_5001;
    mem[32'h0002_0014] = 32'hFFFF_F000;
    mem[32'h0003_0000] = 32'h0000_1001;
    mem[32'h0004_0000] = 32'h0005_0001;
    mem[32'h0005_0004] = 32'h7777_7001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    set_root(20'h00010);
    t_basic();
    t_extremes();
    t_outer_miss();
    t_inner_miss();
    t_latency();
    t_root_midwalk();
    t_busy_request();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule